// File: doc/BRIEF.md
# Synonym Remapping Front End for a Virtually Addressed L1 Cache

This block stands between a core's load/store port and an L1 cache that is both indexed and tagged with virtual addresses. Its job is to keep one physical page from being cached under two virtual names. For every physical page with lines in the L1 it records a single owning ("leader") virtual page number. Data from that page is placed and found only under the leader number. A request that already uses a leader number goes to the cache unchanged. A request that uses a known synonym is rewritten to the leader number, at the cost of one extra cycle.

Translation is not done on every access. The TLB port is used only after the cache reports a miss. The returned physical page number then decides what happens next. If the page has no leader yet, the requester becomes its leader. If the leader is this same virtual page, nothing more is done. If another virtual page is the leader, a small remap entry is written from the requester to the leader, and the access is replayed under the leader number.

The cache reports when the last line of a page leaves the L1. The block then drops that page's leader and every remap entry that points to it. Requests are handled one at a time and in order. Both the core side and the cache side use a valid/ready handshake.

Top module: `syn_remap_unit`

## Requirements
- R1: An accepted request whose virtual page has no remap entry appears on the cache side one cycle after acceptance, with the same page number and offset.
- R2: An accepted request whose virtual page has a remap entry appears on the cache side two cycles after acceptance. It carries the leader page number and the unchanged offset.
- R3: A TLB request is raised only in the cycle after a miss response to a first (non-replayed) lookup. It carries the page number that was looked up. A hit response returns the unit to idle with no TLB request.
- R4: When the translated physical page has no leader, the requester becomes its leader and the unit returns to idle without a replay. Each physical page has at most one leader.
- R5: When the translated physical page has a leader with a different virtual page number, a remap entry from requester to leader is written. The access is reissued to the cache with the leader number one cycle after the translation arrives. Later requests with the requester page are then remapped (R2).
- R6: When the leader of the translated page is the requesting page itself, the unit returns to idle with no replay and no new entry.
- R7: A miss response to a replayed lookup does not start another translation. The unit returns to idle.
- R8: When a remap entry is needed and the remap table is full, the unit stalls. During the stall core_ready and cache_valid stay low, until a release frees an entry.
- R9: A release pulse (evict_valid with a leader page number) removes that leader and all remap entries pointing to it. Afterwards a former synonym page passes unchanged (R1).
- R10: core_ready is high only while the unit is idle and no release pulse is present.
- R11: After reset core_ready is high, cache_valid and tlb_req_valid are low, and both tables are empty.
- R12: While cache_valid is high and cache_ready is low, cache_valid stays high and the page number and offset stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Unit accepts a core request |
| core_vpn | input | VPN_W | Virtual page number of the request |
| core_off | input | OFF_W | Page offset of the request |
| cache_valid | output | 1 | Lookup request to the L1 |
| cache_ready | input | 1 | L1 accepts the lookup |
| cache_vpn | output | VPN_W | Page number used for the lookup |
| cache_off | output | OFF_W | Page offset used for the lookup |
| cache_rsp_valid | input | 1 | L1 lookup outcome present |
| cache_rsp_miss | input | 1 | Outcome is a miss (1) or hit (0) |
| tlb_req_valid | output | 1 | Translation request |
| tlb_req_ready | input | 1 | TLB accepts the request |
| tlb_req_vpn | output | VPN_W | Page number to translate |
| tlb_rsp_valid | input | 1 | Translation result present |
| tlb_rsp_ppn | input | PPN_W | Physical page number returned |
| evict_valid | input | 1 | Last line of a page left the L1 |
| evict_vpn | input | VPN_W | Leader page number of that page |

## Verification
The bench maps virtual page v to physical page v mod 8, so every physical page has four candidate virtual names. Directed sequences first build one leader and then several synonyms of it. They then fill the remap table and send a further synonym. This separates the first-touch, same-leader, remap-and-replay and full-table stall outcomes, and also shows that a release lets the stalled request finish. Random requests over 32 pages follow, with random cache-ready back-pressure, random extra misses on leader pages and random release pulses. These tell the one-cycle path from the two-cycle remapped path by latency and page number. They also check that translation follows only first-lookup misses.

// File: rtl/syn_remap_pkg.sv
package syn_remap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REMAP,
    ST_ISSUE,
    ST_WAIT,
    ST_TLBREQ,
    ST_TLBWAIT,
    ST_DECIDE
  } srm_state_e;

  // index of the lowest clear bit among the first n bits, 0 when none is clear
  function automatic int lowest_zero(input logic [63:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!v[i]) r = i;
    end
    return r;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/srm_lead_tbl.sv
module srm_lead_tbl
  import syn_remap_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] q_ppn,
  output logic             q_hit,
  output logic [VPN_W-1:0] q_vpn,
  output logic             full,
  input  logic             alloc_en,
  input  logic [VPN_W-1:0] alloc_vpn,
  input  logic [PPN_W-1:0] alloc_ppn,
  input  logic             rel_en,
  input  logic [VPN_W-1:0] rel_vpn
);
  localparam int IW = idx_width(N);

  logic [N-1:0]     vld, match, kill;
  logic [VPN_W-1:0] t_vpn [N];
  logic [PPN_W-1:0] t_ppn [N];
  logic [IW-1:0]    free_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (t_ppn[g] == q_ppn);
    assign kill[g]  = rel_en && vld[g] && (t_vpn[g] == rel_vpn);
  end

  always_comb begin
    q_vpn = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) q_vpn = q_vpn | t_vpn[i];
    end
  end

  assign q_hit    = |match;
  assign full     = &vld;
  assign free_idx = IW'(lowest_zero(64'(vld), N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld <= vld & ~kill;
      if (alloc_en) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      t_vpn[free_idx] <= alloc_vpn;
      t_ppn[free_idx] <= alloc_ppn;
    end
  end

  assert_one_leader_per_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_leader_alloc_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

endmodule

// File: rtl/srm_remap_tbl.sv
module srm_remap_tbl
  import syn_remap_pkg::*;
#(
  parameter int N     = 4,
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] q_vpn,
  output logic             q_hit,
  output logic [VPN_W-1:0] q_lead,
  output logic             full,
  input  logic             alloc_en,
  input  logic [VPN_W-1:0] alloc_syn,
  input  logic [VPN_W-1:0] alloc_lead,
  input  logic             rel_en,
  input  logic [VPN_W-1:0] rel_lead
);
  localparam int IW = idx_width(N);

  logic [N-1:0]     vld, match, kill;
  logic [VPN_W-1:0] t_syn  [N];
  logic [VPN_W-1:0] t_lead [N];
  logic [IW-1:0]    free_idx;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (t_syn[g] == q_vpn);
    assign kill[g]  = rel_en && vld[g] && (t_lead[g] == rel_lead);
  end

  always_comb begin
    q_lead = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) q_lead = q_lead | t_lead[i];
    end
  end

  assign q_hit    = |match;
  assign full     = &vld;
  assign free_idx = IW'(lowest_zero(64'(vld), N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld <= vld & ~kill;
      if (alloc_en) vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      t_syn[free_idx]  <= alloc_syn;
      t_lead[free_idx] <= alloc_lead;
    end
  end

  assert_one_remap_per_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_remap_alloc_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

endmodule

// File: rtl/syn_remap_unit.sv
module syn_remap_unit
  import syn_remap_pkg::*;
#(
  parameter int VPN_W        = 20,
  parameter int PPN_W        = 16,
  parameter int OFF_W        = 12,
  parameter int LEAD_N       = 8,
  parameter int SYN_PAGES    = 4,
  parameter int SYN_PER_PAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_valid,
  output logic             core_ready,
  input  logic [VPN_W-1:0] core_vpn,
  input  logic [OFF_W-1:0] core_off,
  output logic             cache_valid,
  input  logic             cache_ready,
  output logic [VPN_W-1:0] cache_vpn,
  output logic [OFF_W-1:0] cache_off,
  input  logic             cache_rsp_valid,
  input  logic             cache_rsp_miss,
  output logic             tlb_req_valid,
  input  logic             tlb_req_ready,
  output logic [VPN_W-1:0] tlb_req_vpn,
  input  logic             tlb_rsp_valid,
  input  logic [PPN_W-1:0] tlb_rsp_ppn,
  input  logic             evict_valid,
  input  logic [VPN_W-1:0] evict_vpn
);
  localparam int REMAP_N = SYN_PAGES * (SYN_PER_PAGE - 1);

  srm_state_e       state;
  logic [VPN_W-1:0] cur_vpn;
  logic [OFF_W-1:0] cur_off;
  logic [PPN_W-1:0] cur_ppn;
  logic             replay;

  // named events
  logic             core_acc, rm_hit, ld_hit, ld_full, rm_full;
  logic             decide_go, ld_alloc, rm_alloc, same_lead;
  logic [VPN_W-1:0] rm_lead, ld_vpn;

  assign core_ready  = (state == ST_IDLE) && !evict_valid;
  assign core_acc    = core_valid && core_ready;
  assign cache_valid = (state == ST_ISSUE);
  assign cache_vpn   = cur_vpn;
  assign cache_off   = cur_off;
  assign tlb_req_valid = (state == ST_TLBREQ);
  assign tlb_req_vpn   = cur_vpn;

  assign decide_go = (state == ST_DECIDE) && !evict_valid;
  assign same_lead = ld_hit && (ld_vpn == cur_vpn);
  assign ld_alloc  = decide_go && !ld_hit && !ld_full;
  assign rm_alloc  = decide_go && ld_hit && !same_lead && !rm_full;

  srm_remap_tbl #(.N(REMAP_N), .VPN_W(VPN_W)) u_remap (
    .clk(clk), .rst_n(rst_n),
    .q_vpn(core_vpn), .q_hit(rm_hit), .q_lead(rm_lead), .full(rm_full),
    .alloc_en(rm_alloc), .alloc_syn(cur_vpn), .alloc_lead(ld_vpn),
    .rel_en(evict_valid), .rel_lead(evict_vpn)
  );

  srm_lead_tbl #(.N(LEAD_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_lead (
    .clk(clk), .rst_n(rst_n),
    .q_ppn(cur_ppn), .q_hit(ld_hit), .q_vpn(ld_vpn), .full(ld_full),
    .alloc_en(ld_alloc), .alloc_vpn(cur_vpn), .alloc_ppn(cur_ppn),
    .rel_en(evict_valid), .rel_vpn(evict_vpn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_vpn <= '0;
      cur_off <= '0;
      cur_ppn <= '0;
      replay  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (core_acc) begin
          cur_vpn <= rm_hit ? rm_lead : core_vpn;
          cur_off <= core_off;
          replay  <= 1'b0;
          state   <= rm_hit ? ST_REMAP : ST_ISSUE;
        end
        ST_REMAP: state <= ST_ISSUE;
        ST_ISSUE: if (cache_ready) state <= ST_WAIT;
        ST_WAIT: if (cache_rsp_valid) begin
          state <= (cache_rsp_miss && !replay) ? ST_TLBREQ : ST_IDLE;
        end
        ST_TLBREQ: if (tlb_req_ready) state <= ST_TLBWAIT;
        ST_TLBWAIT: if (tlb_rsp_valid) begin
          cur_ppn <= tlb_rsp_ppn;
          state   <= ST_DECIDE;
        end
        ST_DECIDE: if (decide_go) begin
          if (ld_alloc || same_lead) begin
            state <= ST_IDLE;
          end else if (rm_alloc) begin
            cur_vpn <= ld_vpn;
            replay  <= 1'b1;
            state   <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_acc && !rm_hit |=> cache_valid && cache_vpn == $past(core_vpn) && cache_off == $past(core_off));

  assert_remap_extra_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_acc && rm_hit |=> !cache_valid);

  assert_tlb_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlb_req_valid) |-> $past(cache_rsp_valid && cache_rsp_miss && !replay));

  assert_replay_uses_leader_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rm_alloc |=> cache_valid && cache_vpn == $past(ld_vpn));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE) && ld_hit && !same_lead && rm_full |=> !cache_valid && !core_ready);

  assert_no_accept_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !core_ready);

  assert_cache_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid && !cache_ready |=> cache_valid && $stable(cache_vpn) && $stable(cache_off));

endmodule

// File: tb/tb_syn_remap_unit.sv
`timescale 1ns/1ps
module tb_syn_remap_unit;
  localparam int VPN_W = 20, PPN_W = 16, OFF_W = 12, RM_CAP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_valid = 0, core_ready;
  logic [VPN_W-1:0] core_vpn = '0;
  logic [OFF_W-1:0] core_off = '0;
  logic cache_valid, cache_ready = 0;
  logic [VPN_W-1:0] cache_vpn;
  logic [OFF_W-1:0] cache_off;
  logic cache_rsp_valid = 0, cache_rsp_miss = 0;
  logic tlb_req_valid, tlb_req_ready = 1'b1;
  logic [VPN_W-1:0] tlb_req_vpn;
  logic tlb_rsp_valid = 0;
  logic [PPN_W-1:0] tlb_rsp_ppn = '0;
  logic evict_valid = 0;
  logic [VPN_W-1:0] evict_vpn = '0;

  always #2.5 clk = ~clk;

  syn_remap_unit dut (.*);

  int total = 0, bad = 0;

  // bench model: leader per physical page, remap list
  bit               lv   [8];
  logic [VPN_W-1:0] lvpn [8];
  int               rcnt = 0;
  logic [VPN_W-1:0] rsyn [RM_CAP];
  logic [VPN_W-1:0] rlead[RM_CAP];

  function automatic int ppn_of(input logic [VPN_W-1:0] v);
    return int'(v % 8);
  endfunction

  function automatic bit is_leader(input logic [VPN_W-1:0] v);
    return lv[ppn_of(v)] && lvpn[ppn_of(v)] == v;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic release_lead(input logic [VPN_W-1:0] v);
    int k;
    evict_valid = 1'b1; evict_vpn = v;
    #0.1;
    chk(core_ready == 1'b0, "R10 core_ready during release", int'(core_ready), 0);
    step();
    evict_valid = 1'b0;
    if (is_leader(v)) lv[ppn_of(v)] = 0;
    k = 0;
    for (int i = 0; i < rcnt; i++) begin
      if (rlead[i] != v) begin rsyn[k] = rsyn[i]; rlead[k] = rlead[i]; k++; end
    end
    rcnt = k;
  endtask

  task automatic cache_hs();
    logic [VPN_W-1:0] pv;
    logic [OFF_W-1:0] po;
    bit r;
    for (int n = 0; n < 20; n++) begin
      pv = cache_vpn; po = cache_off;
      r = ($urandom % 3) != 0;
      cache_ready = r;
      step();
      if (r) break;
      chk(cache_valid && cache_vpn == pv && cache_off == po, "R12 hold under back-pressure",
          int'(cache_vpn), int'(pv));
    end
    cache_ready = 1'b0;
  endtask

  task automatic respond(input bit miss);
    cache_rsp_valid = 1'b1; cache_rsp_miss = miss;
    step();
    cache_rsp_valid = 1'b0; cache_rsp_miss = 1'b0;
  endtask

  task automatic do_req(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off, input string ptag);
    bit hit, miss, done;
    logic [VPN_W-1:0] exp_vpn;
    int exp_lat, lat, p;
    hit = 0; exp_vpn = v;
    for (int i = 0; i < rcnt; i++) if (rsyn[i] == v) begin hit = 1; exp_vpn = rlead[i]; end
    exp_lat = hit ? 2 : 1;
    for (int n = 0; n < 50 && !core_ready; n++) step();
    core_valid = 1'b1; core_vpn = v; core_off = off;
    step();
    core_valid = 1'b0;
    lat = 1;
    while (!cache_valid && lat < 6) begin step(); lat++; end
    chk(lat == exp_lat, {ptag, hit ? " R2 remap latency" : " R1 pass latency"}, lat, exp_lat);
    chk(cache_vpn == exp_vpn, {ptag, hit ? " R2 leader page" : " R1 page unchanged"},
        int'(cache_vpn), int'(exp_vpn));
    chk(cache_off == off, "R1 offset unchanged", int'(cache_off), int'(off));
    cache_hs();
    miss = !is_leader(exp_vpn) || (($urandom % 4) == 0);
    respond(miss);
    if (!miss) begin
      chk(!tlb_req_valid && core_ready, "R3 hit gives no TLB request", int'(tlb_req_valid), 0);
      return;
    end
    chk(tlb_req_valid && tlb_req_vpn == exp_vpn, "R3 TLB request after miss",
        int'(tlb_req_vpn), int'(exp_vpn));
    step();
    tlb_rsp_valid = 1'b1; tlb_rsp_ppn = PPN_W'(ppn_of(exp_vpn));
    step();
    tlb_rsp_valid = 1'b0;
    p = ppn_of(exp_vpn);
    done = 0;
    while (!done) begin
      if (!lv[p]) begin
        lv[p] = 1; lvpn[p] = exp_vpn;
        step();
        chk(core_ready && !cache_valid, "R4 new leader, no replay", int'(cache_valid), 0);
        done = 1;
      end else if (lvpn[p] == exp_vpn) begin
        step();
        chk(core_ready && !cache_valid, "R6 same leader, no replay", int'(cache_valid), 0);
        done = 1;
      end else if (rcnt == RM_CAP) begin
        for (int n = 0; n < 4; n++) begin
          chk(!core_ready && !cache_valid, "R8 stall while remap table full",
              int'(core_ready) + int'(cache_valid), 0);
          step();
        end
        release_lead(rlead[0]);
      end else begin
        rsyn[rcnt] = exp_vpn; rlead[rcnt] = lvpn[p]; rcnt++;
        step();
        chk(cache_valid && cache_vpn == lvpn[p], "R5 replay with leader page",
            int'(cache_vpn), int'(lvpn[p]));
        cache_hs();
        respond(($urandom % 2) == 0);
        chk(!tlb_req_valid && core_ready, "R7 no translation after replay",
            int'(tlb_req_valid), 0);
        done = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) lv[i] = 0;
    repeat (3) @(negedge clk);
    chk(core_ready && !cache_valid && !tlb_req_valid, "R11 reset state",
        int'(cache_valid) + int'(tlb_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_ready == 1'b1, "R11 ready after reset", int'(core_ready), 1);

    // directed: leader, synonyms, full table, release
    do_req(3, 12'h010, "dir");
    do_req(3, 12'h020, "dir");
    do_req(11, 12'h030, "dir");
    do_req(11, 12'h040, "dir");
    do_req(19, 12'h050, "dir");
    do_req(27, 12'h060, "dir");
    do_req(4, 12'h070, "dir");
    do_req(12, 12'h080, "dir");
    do_req(20, 12'h090, "dir");
    do_req(11, 12'h0a0, "R9 after release");
    do_req(28, 12'h0b0, "dir");

    // random phase
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 8) == 0) begin
        int p;
        p = int'($urandom % 8);
        if (lv[p]) release_lead(lvpn[p]);
      end
      do_req(VPN_W'($urandom % 32), OFF_W'($urandom), "rnd");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule